// File: doc/BRIEF.md
# Latched Interrupt Aggregator with Global Gate

This block gathers eleven single-cycle event strobes from neighbouring peripheral logic and holds each one in its own sticky flag. For every source there is an enable bit, a write-one-to-clear bit and a write-one-to-set (force) bit. The force bit lets test software inject an event without the real source.

A single global flag gates the interrupt output. When the global flag is clear and at least one enabled flag is pending, the block sends a one-cycle pulse to the system interrupt expander. In the same cycle it latches the global flag. No further pulse can leave the block until software has written the clear register for the global flag.

Software uses a small synchronous register port to reach the block. A register is picked by a 2-bit address. Writes take effect at the next rising edge and reads are combinational. The port is plain control with no handshake: every write is accepted in the cycle it is presented, so there is no back-pressure.

Top module: `qint_aggregator`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all event flags, all enables and the global flag read 0, and `irq_pulse` is 0.
- R2: An event strobe on `evt_i[k]` sets event flag k at the next rising edge. The flag then stays set until it is cleared.
- R3: A flag latches even when its enable bit is 0. A write to the enable register never changes any flag.
- R4: If the global flag is clear and any flag is both set and enabled at a rising edge, `irq_pulse` is high for exactly the following cycle, and the global flag is set in that same cycle.
- R5: While the global flag is set, `irq_pulse` stays low, whatever events arrive.
- R6: A write to address 2 (clear) clears every flag whose bit is 1. Bit 0 clears the global flag and bit k+1 clears event flag k. Bits written as 0 have no effect.
- R7: A write to address 3 (force) with bit k+1 set sets event flag k, in the same way as a hardware event. Bit 0 of the force register has no effect.
- R8: When a hardware event or a force and a clear hit the same event flag at the same edge, the flag ends up set.
- R9: Read map: address 0 returns the enables on bits 11:1. Address 1 returns the event flags on bits 11:1 and the global flag on bit 0. Addresses 2 and 3 read as 0. Bits 15:12, and bit 0 of address 0, read as 0. Writes to address 1 change nothing.
- R10: Once the global flag is cleared while an enabled event flag is still set, a new pulse follows at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 11 | Single-cycle event strobes, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 enable, 1 flags, 2 clear, 3 force) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq_pulse | output | 1 | One-cycle interrupt pulse to the interrupt expander |

## Verification
The testbench first runs a directed sequence. An event arrives while its source is disabled, which separates latching from gating. The source is then enabled late, and further events arrive while the global flag is set, which shows whether the gate really blocks output. The bench then clears only the global flag and later only the event flag, which shows the re-arm behaviour. Clear and set are made to hit the same flag in one cycle to expose the set-wins ordering. Writes of zero, a write to the flag register, and force bit 0 confirm that these have no effect. A long random mix of events, clears, forces and enable writes follows, and a behavioural reference model checks both the pulse and the read data on every cycle.

// File: rtl/qint_pkg.sv
package qint_pkg;
  localparam int NUM_EV = 11;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE = 2'd0,
    A_FLAGS  = 2'd1,
    A_CLEAR  = 2'd2,
    A_FORCE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/qint_flag_bank.sv
module qint_flag_bank #(
  parameter int N = qint_pkg::NUM_EV
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] frc,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else if (evt[i] || frc[i]) q <= 1'b1;
      else if (clr[i]) q <= 1'b0;
    end
    assign flags[i] = q;

    // R8: an event or force is never lost to a coincident clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) && $past(evt[i] || frc[i]) |-> q);
  end
endmodule

// File: rtl/qint_pulse_gate.sv
module qint_pulse_gate (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic gclr,
  output logic gflag,
  output logic irq_pulse
);
  logic fire;
  assign fire = pending && !gflag;

  always_ff @(posedge clk) begin
    if (rst) begin
      gflag     <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= fire;
      if (fire) gflag <= 1'b1;
      else if (gclr) gflag <= 1'b0;
    end
  end

  // R4: output is a single-cycle pulse
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
  // R4: global flag is latched with the pulse
  p_gflag_with_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> gflag);
  // R5: no pulse unless the gate was open one cycle earlier
  p_gate_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && irq_pulse |-> !$past(gflag));
endmodule

// File: rtl/qint_reg_port.sv
module qint_reg_port
  import qint_pkg::*;
#(
  parameter int N = NUM_EV,
  parameter int W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [N-1:0]      flags,
  input  logic              gflag,
  output logic [N-1:0]      enables,
  output logic [N-1:0]      clr,
  output logic [N-1:0]      frc,
  output logic              gclr,
  output logic [W-1:0]      rdata
);
  logic unused_bits;
  assign unused_bits = ^{wdata[W-1:N+1]};

  logic wr_en, wr_clr, wr_frc;
  assign wr_en  = wr && (reg_sel_e'(addr) == A_ENABLE);
  assign wr_clr = wr && (reg_sel_e'(addr) == A_CLEAR);
  assign wr_frc = wr && (reg_sel_e'(addr) == A_FORCE);

  assign clr  = wr_clr ? wdata[N:1] : '0;
  assign gclr = wr_clr && wdata[0];
  assign frc  = wr_frc ? wdata[N:1] : '0;

  always_ff @(posedge clk) begin
    if (rst) enables <= '0;
    else if (wr_en) enables <= wdata[N:1];
  end

  always_comb begin
    rdata = '0;
    case (reg_sel_e'(addr))
      A_ENABLE: rdata[N:1] = enables;
      A_FLAGS:  rdata[N:0] = {flags, gflag};
      default:  rdata = '0;
    endcase
  end

  // R3: enables change only through an enable write
  p_enable_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$past(wr_en) |-> $stable(enables));
endmodule

// File: rtl/qint_aggregator.sv
module qint_aggregator
  import qint_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] evt_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_pulse
);
  logic [NUM_EV-1:0] flags, enables, clr, frc;
  logic gflag, gclr;

  qint_reg_port #(.N(NUM_EV), .W(REG_W)) u_port (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flags(flags), .gflag(gflag), .enables(enables), .clr(clr), .frc(frc),
    .gclr(gclr), .rdata(reg_rdata)
  );

  qint_flag_bank #(.N(NUM_EV)) u_flags (
    .clk(clk), .rst(rst), .evt(evt_i), .frc(frc), .clr(clr), .flags(flags)
  );

  qint_pulse_gate u_gate (
    .clk(clk), .rst(rst), .pending(|(flags & enables)), .gclr(gclr),
    .gflag(gflag), .irq_pulse(irq_pulse)
  );

  // R2: a strobe leaves its flag set at the next edge
  p_event_latch_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(evt_i != '0) |-> ((flags & $past(evt_i)) == $past(evt_i)));
endmodule

// File: tb/qint_aggregator_bench.sv
module qint_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] evt = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int errs = 0, checks = 0;
  string cur_req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  qint_aggregator u_qint_aggregator (
    .clk(clk), .rst(rst), .evt_i(evt), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_pulse(irq)
  );

  // behavioural reference model
  logic [11:0] m_en = '0, m_flg = '0;
  logic        m_pulse = 1'b0;
  always @(posedge clk) begin
    logic cond;
    logic [11:0] clrv, frcv, nf;
    if (rst) begin
      m_en = '0; m_flg = '0; m_pulse = 1'b0;
    end else begin
      cond = !m_flg[0] && ((m_flg & m_en & 12'hFFE) != 0);
      clrv = (wr && addr == 2'd2) ? wdata[11:0] : 12'h000;
      frcv = (wr && addr == 2'd3) ? (wdata[11:0] & 12'hFFE) : 12'h000;
      nf = (m_flg & ~clrv) | {evt, 1'b0} | frcv;
      nf[0] = (m_flg[0] & ~clrv[0]) | cond;
      if (wr && addr == 2'd0) m_en = wdata[11:0] & 12'hFFE;
      m_flg = nf;
      m_pulse = cond;
    end
  end

  always @(posedge clk) begin
    logic [15:0] exp_rd;
    #5;
    if (!done) begin
      exp_rd = (addr == 2'd0) ? {4'h0, m_en} : (addr == 2'd1) ? {4'h0, m_flg} : 16'h0000;
      checks++;
      if (irq !== m_pulse) begin
        errs++;
        $display("FAIL %s irq_pulse actual=%b expected=%b t=%0t", cur_req, irq, m_pulse, $time);
      end
      checks++;
      if (rdata !== exp_rd) begin
        errs++;
        $display("FAIL %s rdata@%0d actual=%h expected=%h t=%0t", cur_req, addr, rdata, exp_rd, $time);
      end
    end
  end

  task automatic step(input bit w, input logic [1:0] a, input logic [15:0] d,
                      input logic [10:0] e);
    @(negedge clk);
    wr = w; addr = a; wdata = d; evt = e;
    @(negedge clk);
    wr = 1'b0; evt = '0; addr = 2'd1;
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr = 1'b0; evt = '0; addr = a;
    end
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2, 2'd1);
    idle(1, 2'd0);
    cur_req = "R3";               // latch while disabled, no pulse
    step(0, 2'd1, 16'h0, 11'h004);
    idle(3, 2'd1);
    cur_req = "R4";               // enable late: pulse follows
    step(1, 2'd0, 16'h0008, 11'h0);
    idle(3, 2'd1);
    cur_req = "R5";               // gate closed: new events give no pulse
    step(0, 2'd1, 16'h0, 11'h001);
    step(1, 2'd0, 16'h0FFE, 11'h0);
    idle(3, 2'd1);
    cur_req = "R10";              // clear global only: re-fire
    step(1, 2'd2, 16'h0001, 11'h0);
    idle(3, 2'd1);
    cur_req = "R6";               // clear all, then zero-write
    step(1, 2'd2, 16'h0FFF, 11'h0);
    step(1, 2'd2, 16'h0000, 11'h0);
    idle(3, 2'd1);
    cur_req = "R7";               // force with bit 0 set
    step(1, 2'd3, 16'hF201, 11'h0);
    idle(3, 2'd1);
    cur_req = "R8";               // clear and event on the same flag
    step(1, 2'd2, 16'h0FFF, 11'h100);
    idle(2, 2'd1);
    step(1, 2'd2, 16'h0002, 11'h0);
    idle(1, 2'd1);
    cur_req = "R9";               // flag register write ignored; strobes read 0
    step(1, 2'd1, 16'hFFFF, 11'h0);
    idle(2, 2'd2);
    idle(2, 2'd3);
    idle(2, 2'd0);
    cur_req = "R2";               // random mix
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      evt   = ($urandom % 4 == 0) ? 11'($urandom) : 11'h0;
      wr    = ($urandom % 3 == 0);
      addr  = 2'($urandom);
      wdata = 16'($urandom);
    end
    idle(2, 2'd1);
    cur_req = "R1";
    @(negedge clk) rst = 1'b1;
    idle(2, 2'd1);
    @(negedge clk) rst = 1'b0;
    idle(2, 2'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule